// File: doc/BRIEF.md
# Iterative Extended Arithmetic Unit

This unit carries out the long-running arithmetic of a word-oriented processor on a register group made of a one-bit link, a W-bit accumulator and a W-bit multiplier-quotient word, together with a step counter. It shifts that 2W+1-bit chain left, logically right or arithmetically right under a loadable count. It can normalize the chain. It forms an unsigned multiply-accumulate, accumulator plus operand times MQ. It divides the double word {AC, MQ} by an operand, with unsigned values. It can also load the step counter from the accumulator. The unit advances one bit per clock cycle.

A command carries a 4-bit operation code, an operand word and the current link, AC, MQ and counter values. It is handed over with a valid/ready handshake. `cmd_ready` is high only while the unit is idle, and a command is taken in a cycle where `cmd_valid` and `cmd_ready` are both high. Holding `cmd_valid` while `cmd_ready` is low stalls nothing and changes nothing. The result has no back-pressure: `done` is high for exactly one cycle. In that cycle `out_link`, `out_ac`, `out_mq` and `out_sc` hold the finished values. They keep those values until the next command is accepted. `busy` is high from the cycle after acceptance up to, but not including, the `done` cycle.

Top module: `eae_unit`

## Requirements
- R1: A command is accepted only in a cycle with `cmd_valid` and `cmd_ready` both high, and `cmd_ready` is high only when idle. `busy` then stays high for N cycles, `done` follows for one cycle, and `cmd_ready` returns the cycle after that. N is the step count of the operation plus one.
- R2: After reset `cmd_ready` is 1, `busy` and `done` are 0, and all result outputs are 0.
- R3: Code 0 (shift left) repeats SC times. Each step moves AC bit 31 into the link, MQ bit 31 into AC bit 0, and 0 into MQ bit 0. SC ends at 0, and N = SC + 1.
- R4: Code 1 (logical right) repeats SC times. Each step clears the link, shifts AC right with 0 entering at the top, and moves AC bit 0 into MQ bit 31. SC ends at 0, and with SC = 0 nothing changes.
- R5: Code 2 (arithmetic right) matches code 1, except that each step copies AC bit 31 back into AC bit 31.
- R6: Code 3 (normalize) clears SC, then shifts left as in R3 and adds 1 to SC per step. It stops when AC bits 31 and 30 differ, or when AC is 0xC000_0000 with MQ 0, or when SC reaches 64. N = steps + 1.
- R7: Code 4 (multiply) returns AC + operand × MQ as an unsigned 64-bit value, high half in AC and low half in MQ. It clears the link and SC, and N = 33.
- R8: Code 5 (divide) with AC < operand returns the quotient of {AC,MQ} / operand in MQ and the remainder in AC. It clears the link and SC, and N = 33.
- R9: Code 5 with AC ≥ operand (this includes operand 0) leaves AC and MQ unchanged, sets the link to 1 and SC to 0, and N = 1.
- R10: Code 6 loads SC from AC bits 6:0 and clears AC. The link and MQ are unchanged, and N = 1.
- R11: Codes 7 to 15 change nothing, and N = 1.
- R12: A command presented while the unit is busy or signalling done is ignored and does not alter the running result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_op | input | 4 | Operation code |
| cmd_y | input | W | Operand word for multiply/divide |
| in_link | input | 1 | Link value at start |
| in_ac | input | W | Accumulator value at start |
| in_mq | input | W | MQ value at start |
| in_sc | input | SCW | Step count for shifts |
| busy | output | 1 | Iterating |
| done | output | 1 | One-cycle result strobe |
| out_link | output | 1 | Resulting link |
| out_ac | output | W | Resulting accumulator |
| out_mq | output | W | Resulting MQ |
| out_sc | output | SCW | Resulting step counter |

## Verification
The bench builds the unit with its defaults: W = 32, SCW = 7 and a normalize limit of 64. A 7-bit count reaches up to 127 shifts, which is well past the 65-bit chain, so every bit can be pushed out of it. The limit of 64 equals the width of the AC:MQ pair, so an all-zero normalize runs into the cap. With 32-bit words, a multiply-accumulate whose sum fills all 64 bits is in range, and so are divides with large quotients.

// File: rtl/eae_pkg.sv
package eae_pkg;
  localparam logic [3:0] OPC_SHL  = 4'd0;
  localparam logic [3:0] OPC_LSR  = 4'd1;
  localparam logic [3:0] OPC_ASR  = 4'd2;
  localparam logic [3:0] OPC_NORM = 4'd3;
  localparam logic [3:0] OPC_MUL  = 4'd4;
  localparam logic [3:0] OPC_DIV  = 4'd5;
  localparam logic [3:0] OPC_LDSC = 4'd6;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} eae_state_e;
  typedef enum logic [1:0] {SH_LEFT, SH_LOGIC, SH_ARITH} shift_mode_e;
endpackage

// File: rtl/eae_shift_step.sv
module eae_shift_step
  import eae_pkg::*;
#(
  parameter int W = 32
) (
  input  shift_mode_e    mode,
  input  logic           l_i,
  input  logic [W-1:0]   ac_i,
  input  logic [W-1:0]   mq_i,
  output logic           l_o,
  output logic [W-1:0]   ac_o,
  output logic [W-1:0]   mq_o
);
  always_comb begin
    case (mode)
      SH_LEFT: begin
        l_o  = ac_i[W-1];
        ac_o = {ac_i[W-2:0], mq_i[W-1]};
        mq_o = {mq_i[W-2:0], 1'b0};
      end
      SH_LOGIC: begin
        l_o  = 1'b0;
        ac_o = {1'b0, ac_i[W-1:1]};
        mq_o = {ac_i[0], mq_i[W-1:1]};
      end
      SH_ARITH: begin
        l_o  = 1'b0;
        ac_o = {ac_i[W-1], ac_i[W-1:1]};
        mq_o = {ac_i[0], mq_i[W-1:1]};
      end
      default: begin
        l_o  = l_i;
        ac_o = ac_i;
        mq_o = mq_i;
      end
    endcase
  end
endmodule

// File: rtl/eae_mul_step.sv
module eae_mul_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] ac_i,
  input  logic [W-1:0] mq_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] ac_o,
  output logic [W-1:0] mq_o
);
  logic [W:0] partial;

  // Add the operand when the multiplier bit is set, then shift the pair right.
  always_comb begin
    partial = mq_i[0] ? ({1'b0, ac_i} + {1'b0, y_i}) : {1'b0, ac_i};
    ac_o    = partial[W:1];
    mq_o    = {partial[0], mq_i[W-1:1]};
  end
endmodule

// File: rtl/eae_div_step.sv
module eae_div_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] ac_i,
  input  logic [W-1:0] mq_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] ac_o,
  output logic [W-1:0] mq_o
);
  logic [W:0] shifted;
  logic [W:0] diff;
  logic       fits;

  // Restoring step: bring down the next dividend bit, subtract when it fits.
  always_comb begin
    shifted = {ac_i, mq_i[W-1]};
    diff    = shifted - {1'b0, y_i};
    fits    = (shifted >= {1'b0, y_i});
    ac_o    = fits ? diff[W-1:0] : shifted[W-1:0];
    mq_o    = {mq_i[W-2:0], fits};
  end
endmodule

// File: rtl/eae_unit.sv
module eae_unit
  import eae_pkg::*;
#(
  parameter int W          = 32,
  parameter int SCW        = 7,
  parameter int NORM_LIMIT = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [3:0]     cmd_op,
  input  logic [W-1:0]   cmd_y,
  input  logic           in_link,
  input  logic [W-1:0]   in_ac,
  input  logic [W-1:0]   in_mq,
  input  logic [SCW-1:0] in_sc,
  output logic           busy,
  output logic           done,
  output logic           out_link,
  output logic [W-1:0]   out_ac,
  output logic [W-1:0]   out_mq,
  output logic [SCW-1:0] out_sc
);
  localparam int             MD_STEPS = W;
  localparam int             ITW      = $clog2(MD_STEPS + 1);
  localparam logic [ITW-1:0] MD_LAST  = ITW'(MD_STEPS);
  localparam logic [SCW-1:0] NORM_CAP = SCW'(NORM_LIMIT);
  localparam logic [W-1:0]   NORM_END = {2'b11, {(W-2){1'b0}}};

  eae_state_e     state;
  logic [3:0]     op_q;
  logic [W-1:0]   y_q;
  logic           l_q;
  logic [W-1:0]   ac_q;
  logic [W-1:0]   mq_q;
  logic [SCW-1:0] sc_q;
  logic [ITW-1:0] it_q;

  shift_mode_e    sh_mode;
  logic           sh_l;
  logic [W-1:0]   sh_ac, sh_mq;
  logic [W-1:0]   mul_ac, mul_mq;
  logic [W-1:0]   div_ac, div_mq;
  logic           div_ovf;
  logic           norm_hit;
  logic           finish;

  always_comb begin
    case (op_q)
      OPC_LSR: sh_mode = SH_LOGIC;
      OPC_ASR: sh_mode = SH_ARITH;
      default: sh_mode = SH_LEFT;
    endcase
  end

  eae_shift_step #(.W(W)) u_shift (
    .mode(sh_mode), .l_i(l_q), .ac_i(ac_q), .mq_i(mq_q),
    .l_o(sh_l), .ac_o(sh_ac), .mq_o(sh_mq)
  );

  eae_mul_step #(.W(W)) u_mul (
    .ac_i(ac_q), .mq_i(mq_q), .y_i(y_q), .ac_o(mul_ac), .mq_o(mul_mq)
  );

  eae_div_step #(.W(W)) u_div (
    .ac_i(ac_q), .mq_i(mq_q), .y_i(y_q), .ac_o(div_ac), .mq_o(div_mq)
  );

  // Termination decision for the current iteration cycle.
  always_comb begin
    div_ovf  = (it_q == '0) && (ac_q >= y_q);
    norm_hit = (ac_q[W-1] != ac_q[W-2]) ||
               ((ac_q == NORM_END) && (mq_q == '0)) ||
               (sc_q == NORM_CAP);
    case (op_q)
      OPC_SHL, OPC_LSR, OPC_ASR: finish = (sc_q == '0);
      OPC_NORM:                  finish = norm_hit;
      OPC_MUL:                   finish = (it_q == MD_LAST);
      OPC_DIV:                   finish = div_ovf || (it_q == MD_LAST);
      default:                   finish = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_q  <= '0;
      y_q   <= '0;
      l_q   <= 1'b0;
      ac_q  <= '0;
      mq_q  <= '0;
      sc_q  <= '0;
      it_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q  <= cmd_op;
            y_q   <= cmd_y;
            l_q   <= in_link;
            ac_q  <= in_ac;
            mq_q  <= in_mq;
            sc_q  <= (cmd_op == OPC_NORM) ? '0 : in_sc;
            it_q  <= '0;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (finish) begin
            state <= ST_DONE;
            case (op_q)
              OPC_MUL: begin
                l_q  <= 1'b0;
                sc_q <= '0;
              end
              OPC_DIV: begin
                l_q  <= div_ovf;
                sc_q <= '0;
              end
              OPC_LDSC: begin
                sc_q <= ac_q[SCW-1:0];
                ac_q <= '0;
              end
              default: ;
            endcase
          end else begin
            case (op_q)
              OPC_SHL, OPC_LSR, OPC_ASR: begin
                l_q  <= sh_l;
                ac_q <= sh_ac;
                mq_q <= sh_mq;
                sc_q <= sc_q - 1'b1;
              end
              OPC_NORM: begin
                l_q  <= sh_l;
                ac_q <= sh_ac;
                mq_q <= sh_mq;
                sc_q <= sc_q + 1'b1;
              end
              OPC_MUL: begin
                ac_q <= mul_ac;
                mq_q <= mul_mq;
                it_q <= it_q + 1'b1;
              end
              OPC_DIV: begin
                ac_q <= div_ac;
                mq_q <= div_mq;
                it_q <= it_q + 1'b1;
              end
              default: ;
            endcase
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign busy      = (state == ST_RUN);
  assign done      = (state == ST_DONE);
  assign out_link  = l_q;
  assign out_ac    = ac_q;
  assign out_mq    = mq_q;
  assign out_sc    = sc_q;
endmodule

// File: rtl/eae_unit_chk.sv
module eae_unit_chk
  import eae_pkg::*;
#(
  parameter int W          = 32,
  parameter int SCW        = 7,
  parameter int NORM_LIMIT = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic [3:0]     cmd_op,
  input logic [W-1:0]   cmd_y,
  input logic [W-1:0]   in_ac,
  input logic           busy,
  input logic           done,
  input logic           out_link,
  input logic [W-1:0]   out_ac,
  input logic [W-1:0]   out_mq,
  input logic [SCW-1:0] out_sc
);
  localparam logic [SCW-1:0] CAP = SCW'(NORM_LIMIT);
  localparam logic [W-1:0]   TOP = {2'b11, {(W-2){1'b0}}};

  logic [3:0]   cap_op;
  logic [W-1:0] cap_ac;
  logic [W-1:0] cap_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_op <= '0;
      cap_ac <= '0;
      cap_y  <= '0;
    end else if (cmd_valid && cmd_ready) begin
      cap_op <= cmd_op;
      cap_ac <= in_ac;
      cap_y  <= cmd_y;
    end
  end

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || done) |-> !cmd_ready); // R1
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready)); // R1
  AST_SHIFT_SC: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (cap_op == OPC_SHL || cap_op == OPC_LSR || cap_op == OPC_ASR)) |-> (out_sc == '0)); // R3
  AST_NORM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_op == OPC_NORM) |->
      ((out_ac[W-1] != out_ac[W-2]) || (out_ac == TOP && out_mq == '0) || (out_sc == CAP))); // R6
  AST_MUL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_op == OPC_MUL) |-> (!out_link && out_sc == '0)); // R7
  AST_DIV_REM: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_op == OPC_DIV && cap_ac < cap_y) |-> (!out_link && out_ac < cap_y)); // R8
  AST_DIV_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_op == OPC_DIV && cap_ac >= cap_y) |-> (out_link && out_ac == cap_ac && out_sc == '0)); // R9
  AST_LOAD_SC: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_op == OPC_LDSC) |-> (out_ac == '0 && out_sc == cap_ac[SCW-1:0])); // R10
endmodule

bind eae_unit eae_unit_chk #(.W(W), .SCW(SCW), .NORM_LIMIT(NORM_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_y(cmd_y), .in_ac(in_ac), .busy(busy), .done(done),
  .out_link(out_link), .out_ac(out_ac), .out_mq(out_mq), .out_sc(out_sc)
);

// File: tb/tb_eae_unit.sv
`timescale 1ns/1ps
module tb_eae_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = '0;
  logic [31:0] cmd_y = '0;
  logic        in_link = 1'b0;
  logic [31:0] in_ac = '0;
  logic [31:0] in_mq = '0;
  logic [6:0]  in_sc = '0;
  logic        busy, done, out_link;
  logic [31:0] out_ac, out_mq;
  logic [6:0]  out_sc;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  // model state
  int          mst = 0;
  int          m_left = 0;
  bit          intr_q = 0;
  logic        e_l;
  logic [31:0] e_ac, e_mq;
  logic [6:0]  e_sc;
  int          e_n;
  string       e_tag = "R1";

  always #10 clk = ~clk;

  eae_unit dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_y(cmd_y), .in_link(in_link), .in_ac(in_ac),
    .in_mq(in_mq), .in_sc(in_sc), .busy(busy), .done(done),
    .out_link(out_link), .out_ac(out_ac), .out_mq(out_mq), .out_sc(out_sc)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic ref_model(input logic [3:0] op, input logic [31:0] y, input logic l,
                           input logic [31:0] ac, input logic [31:0] mq, input logic [6:0] sc);
    logic [64:0] v;
    logic [63:0] p, dv;
    int k;
    v = {l, ac, mq};
    e_sc = sc;
    e_n = 1;
    case (op)
      4'd0: begin
        for (int i = 0; i < int'(sc); i++) v = v << 1;
        e_sc = '0; e_n = int'(sc) + 1; e_tag = "R3";
      end
      4'd1: begin
        for (int i = 0; i < int'(sc); i++) v = {2'b00, v[63:1]};
        e_sc = '0; e_n = int'(sc) + 1; e_tag = "R4";
      end
      4'd2: begin
        for (int i = 0; i < int'(sc); i++) v = {1'b0, v[63], v[63:1]};
        e_sc = '0; e_n = int'(sc) + 1; e_tag = "R5";
      end
      4'd3: begin
        k = 0;
        while (!((v[63] != v[62]) || (v[63:0] == 64'hC000_0000_0000_0000)) && k < 64) begin
          v = v << 1;
          k++;
        end
        e_sc = 7'(k); e_n = k + 1; e_tag = "R6";
      end
      4'd4: begin
        p = 64'(ac) + 64'(y) * 64'(mq);
        v = {1'b0, p};
        e_sc = '0; e_n = 33; e_tag = "R7";
      end
      4'd5: begin
        if (ac >= y) begin
          v[64] = 1'b1; e_n = 1; e_tag = "R9";
        end else begin
          dv = {ac, mq};
          v = {1'b0, 32'(dv % 64'(y)), 32'(dv / 64'(y))};
          e_n = 33; e_tag = "R8";
        end
        e_sc = '0;
      end
      4'd6: begin
        e_sc = ac[6:0]; v[63:32] = '0; e_tag = "R10";
      end
      default: e_tag = "R11";
    endcase
    e_l = v[64]; e_ac = v[63:32]; e_mq = v[31:0];
  endtask

  // Reference progression, advanced on each rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0;
    end else begin
      case (mst)
        0: if (cmd_valid) begin
          ref_model(cmd_op, cmd_y, in_link, in_ac, in_mq, in_sc);
          if (intr_q) e_tag = "R12";
          m_left = e_n;
          mst = 1;
        end
        1: begin
          m_left--;
          if (m_left == 0) mst = 2;
        end
        default: mst = 0;
      endcase
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1", 64'(busy), 64'(mst == 1), "busy");
      chk("R1", 64'(cmd_ready), 64'(mst == 0), "cmd_ready");
      chk("R1", 64'(done), 64'(mst == 2), "done");
      if (mst == 2) begin
        chk(e_tag, 64'(out_link), 64'(e_l), "link");
        chk(e_tag, 64'(out_ac), 64'(e_ac), "ac");
        chk(e_tag, 64'(out_mq), 64'(e_mq), "mq");
        chk(e_tag, 64'(out_sc), 64'(e_sc), "sc");
      end
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] y, input logic l,
                       input logic [31:0] ac, input logic [31:0] mq, input logic [6:0] sc,
                       input bit intr);
    int guard;
    @(negedge clk);
    cmd_op = op; cmd_y = y; in_link = l; in_ac = ac; in_mq = mq; in_sc = sc;
    intr_q = intr;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    intr_q = 0;
    if (intr) begin
      // R12: a competing command offered while the unit is busy
      cmd_op = 4'd6; in_ac = 32'hFFFF_FFFF; in_mq = '0; in_sc = 7'd3;
      cmd_valid = 1'b1;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
    end
    guard = 0;
    while (!done && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 1000) begin
      nchk++; nerr++;
      $display("FAIL R1 done missing actual=0 expected=1");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk("R2", 64'(cmd_ready), 64'd1, "ready after reset");
    chk("R2", 64'(busy), 64'd0, "busy after reset");
    chk("R2", 64'(done), 64'd0, "done after reset");
    chk("R2", {31'd0, out_link, out_ac}, 64'd0, "link/ac after reset");
    chk("R2", {25'd0, out_sc, out_mq}, 64'd0, "sc/mq after reset");

    issue(4'd0, 32'h0, 1'b0, 32'h9000_0001, 32'h8000_0003, 7'd4, 0);   // R3
    issue(4'd0, 32'h0, 1'b1, 32'h1234_5678, 32'h9ABC_DEF0, 7'd0, 0);   // R3 zero count
    issue(4'd0, 32'h0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 7'd100, 0); // R3 beyond chain
    issue(4'd1, 32'h0, 1'b1, 32'h8000_0005, 32'h0000_00F0, 7'd3, 0);   // R4
    issue(4'd1, 32'h0, 1'b1, 32'hDEAD_BEEF, 32'h0BAD_F00D, 7'd40, 0);  // R4 across words
    issue(4'd1, 32'h0, 1'b1, 32'h0000_0001, 32'h0, 7'd0, 0);           // R4 zero count
    issue(4'd2, 32'h0, 1'b1, 32'h8000_0011, 32'h0000_0001, 7'd5, 0);   // R5
    issue(4'd2, 32'h0, 1'b0, 32'h7000_0000, 32'h0, 7'd33, 0);          // R5 positive
    issue(4'd3, 32'h0, 1'b0, 32'h0000_0010, 32'h0000_0005, 7'd9, 0);   // R6
    issue(4'd3, 32'h0, 1'b0, 32'hFFFF_FFFF, 32'h0, 7'd0, 0);           // R6 terminal pattern
    issue(4'd3, 32'h0, 1'b1, 32'h0, 32'h0, 7'd0, 0);                   // R6 limit
    issue(4'd3, 32'h0, 1'b0, 32'h4000_0000, 32'h1, 7'd5, 0);           // R6 no steps
    issue(4'd4, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 7'd9, 0); // R7 full
    issue(4'd4, 32'h0001_2345, 1'b0, 32'h0000_1234, 32'h0000_ABCD, 7'd1, 0); // R7
    issue(4'd5, 32'h0001_0000, 1'b1, 32'h0000_0005, 32'h1234_5678, 7'd2, 0); // R8
    issue(4'd5, 32'hFFFF_FFFE, 1'b0, 32'hFFFF_FFFD, 32'hFFFF_FFFF, 7'd0, 0); // R8 large
    issue(4'd5, 32'h0000_0007, 1'b0, 32'h0000_0007, 32'h0000_0001, 7'd4, 0); // R9 equal
    issue(4'd5, 32'h0, 1'b0, 32'h0, 32'h5555_5555, 7'd4, 0);                 // R9 zero divisor
    issue(4'd6, 32'h0, 1'b1, 32'h1234_56F3, 32'hCAFE_0000, 7'd1, 0);         // R10
    issue(4'd9, 32'h1, 1'b1, 32'hAAAA_5555, 32'h1357_9BDF, 7'd12, 0);        // R11
    issue(4'd15, 32'h1, 1'b0, 32'h0F0F_0F0F, 32'h0, 7'd3, 0);                // R11
    issue(4'd4, 32'h8765_4321, 1'b0, 32'h1, 32'h1111_1111, 7'd0, 1);         // R12
    issue(4'd0, 32'h0, 1'b0, 32'h0000_0003, 32'h0, 7'd2, 1);                 // R12

    for (int i = 0; i < 24; i++) begin
      logic [3:0]  op;
      logic [31:0] ra, rm, ry;
      op = 4'($urandom_range(0, 8));
      ra = $urandom; rm = $urandom; ry = $urandom;
      if (op == 4'd5 && (i % 2) == 0) begin
        ra = ra >> 4;
        ry = ry | 32'h1000_0000;
      end
      issue(op, ry, 1'($urandom_range(0, 1)), ra, rm, 7'($urandom_range(0, 100)), 0);
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule